// File: doc/BRIEF.md
# Scan-Line Transition Position Encoder and Playback Comparator

This block records where the dark-to-bright transitions of a one-bit video signal fall along each scan line, and replays them one line later as single-clock dot pulses. A tick counter restarts at zero on every line-start strobe and counts clock cycles across the line. Each rising edge of the video bit within the active part of the line stores the current tick count into a bank of position registers. There is room for a fixed number of positions per line.

Two banks swap roles at every line start. The bank filled during the line that just ended becomes the playback bank. Its stored counts are compared, one after another in ascending order, against the running tick counter. A match raises the registered dot output for one clock and moves the playback pointer to the next stored entry. Positions that do not fit in the bank are dropped, and a per-line overflow flag reports it. Because the line is stored as a short list of counts rather than a bitmap, a sparse line drawing costs only a few words per line.

Top module: `lpc_line_codec`

## Requirements
- R1: After reset, dot and ovf are 0. The first line after the first line-start strobe plays back no dots, because both banks start empty.
- R2: Let the tick counter be 0 in the cycle after a line-start strobe, counting up by one per clock. If the video bit is sampled 0 at tick p-1 and 1 at tick p, with p below 512, then count p is stored. In the next line, dot is 1 in the cycle right after the one in which the counter equals p.
- R3: Each stored position gives exactly one dot pulse, one clock long. Positions two counts apart give separate pulses.
- R4: A line's positions play back only during the line after it. A line with no captures, following one that had captures, gives no dots in the line after it.
- R5: Rising edges at tick counts 512 through 599 (the sync interval) are not stored and give no dot in the next line.
- R6: At most 32 positions are stored per line, the first 32 in time order. Later rising edges in that line are dropped.
- R7: ovf goes to 1 after a rising edge in the active part of a line is dropped because the bank is full. It stays 1 until the next line-start strobe and is 0 in the cycle after that strobe. A line with exactly 32 captures leaves ovf at 0.
- R8: Video held high across many cycles counts as one transition, at the tick where it rose.
- R9: A line-start strobe restarts the tick count at 0 whatever its value, so a short line measures positions from its own strobe. Stored entries that were not reached before a strobe are discarded and never replayed in a later line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe marking the start of a scan line |
| video | input | 1 | One-bit video level sampled each clock |
| dot | output | 1 | Registered one-clock pulse at each replayed position |
| ovf | output | 1 | Set when a capture was dropped in the current line; cleared at line start |

## Verification
The bench aims at position 0 and the last active count 511. A design that compared before the counter restarted, or that used an inclusive sync bound, would lose or shift these dots. It places edges inside the sync interval: an edge there that reached playback would show up as an extra dot. It also fills the bank to exactly 32 and then to 40. A full-compare that is off by one would either drop the 32nd entry or raise ovf when nothing was lost. Other cases cover a level held high for hundreds of cycles, which must not be re-captured; positions two counts apart, which would merge if dot lasted two cycles; and a short line cut off by an early strobe. In that last case, an unreached entry that is not discarded would reappear a line later.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  // role of a bank: the one being written in the current line
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/lpc_tick_counter.sv
module lpc_tick_counter #(
  parameter int LINE_LEN = 600,
  localparam int CW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  output logic [CW-1:0] tick
);
  always_ff @(posedge clk) begin
    if (rst || line_start)
      tick <= '0;
    else if (tick == CW'(LINE_LEN - 1))
      tick <= '0;
    else
      tick <= tick + CW'(1);
  end
endmodule

// File: rtl/lpc_capture.sv
module lpc_capture #(
  parameter int LINE_LEN   = 600,
  parameter int ACTIVE_LEN = 512,
  parameter int DEPTH      = 32,
  localparam int CW    = $clog2(LINE_LEN),
  localparam int POS_W = $clog2(ACTIVE_LEN),
  localparam int AW    = $clog2(DEPTH),
  localparam int NW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             video,
  input  logic [CW-1:0]    tick,
  output logic             wr_en,
  output logic [AW-1:0]    wr_idx,
  output logic [POS_W-1:0] wr_pos,
  output logic [NW-1:0]    fill,
  output logic             ovf
);
  logic vid_q;
  logic rise, take, full;

  always_ff @(posedge clk) begin
    if (rst) vid_q <= 1'b0;
    else     vid_q <= video;
  end

  assign rise   = video & ~vid_q;
  assign take   = rise & ~line_start & (tick < CW'(ACTIVE_LEN));
  assign full   = (fill == NW'(DEPTH));
  assign wr_en  = take & ~full;
  assign wr_idx = fill[AW-1:0];
  assign wr_pos = tick[POS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      fill <= '0;
      ovf  <= 1'b0;
    end else if (take) begin
      if (full) ovf  <= 1'b1;
      else      fill <= fill + NW'(1);
    end
  end
endmodule

// File: rtl/lpc_bank.sv
module lpc_bank #(
  parameter int DEPTH = 32,
  parameter int POS_W = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [POS_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [POS_W-1:0] rdata
);
  logic [POS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lpc_playback.sv
module lpc_playback #(
  parameter int LINE_LEN   = 600,
  parameter int ACTIVE_LEN = 512,
  parameter int DEPTH      = 32,
  localparam int CW    = $clog2(LINE_LEN),
  localparam int POS_W = $clog2(ACTIVE_LEN),
  localparam int NW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [CW-1:0]    tick,
  input  logic [NW-1:0]    fill_in,
  input  logic [POS_W-1:0] rd_pos,
  output logic [NW-1:0]    play_ptr,
  output logic [NW-1:0]    play_len,
  output logic             dot
);
  logic [CW-1:0] pos_ext;
  logic          hit;

  assign pos_ext = CW'(rd_pos);
  assign hit     = (play_ptr < play_len) & ~line_start & (tick == pos_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      play_ptr <= '0;
      play_len <= '0;
      dot      <= 1'b0;
    end else begin
      dot <= hit;
      if (line_start) begin
        play_ptr <= '0;
        play_len <= fill_in;
      end else if (hit) begin
        play_ptr <= play_ptr + NW'(1);
      end
    end
  end
endmodule

// File: rtl/lpc_line_codec.sv
module lpc_line_codec
  import lpc_pkg::*;
#(
  parameter int LINE_LEN   = 600,
  parameter int ACTIVE_LEN = 512,
  parameter int DEPTH      = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic video,
  output logic dot,
  output logic ovf
);
  localparam int CW    = $clog2(LINE_LEN);
  localparam int POS_W = $clog2(ACTIVE_LEN);
  localparam int AW    = $clog2(DEPTH);
  localparam int NW    = $clog2(DEPTH + 1);

  logic [CW-1:0]    tick;
  logic             wr_en;
  logic [AW-1:0]    wr_idx;
  logic [POS_W-1:0] wr_pos;
  logic [NW-1:0]    fill;
  logic [NW-1:0]    play_ptr, play_len;
  logic [POS_W-1:0] bank_rd [2];
  logic [POS_W-1:0] rd_pos;
  bank_e            wr_bank;

  always_ff @(posedge clk) begin
    if (rst)             wr_bank <= BANK_A;
    else if (line_start) wr_bank <= other_bank(wr_bank);
  end

  lpc_tick_counter #(.LINE_LEN(LINE_LEN)) u_tick (
    .clk(clk), .rst(rst), .line_start(line_start), .tick(tick)
  );

  lpc_capture #(.LINE_LEN(LINE_LEN), .ACTIVE_LEN(ACTIVE_LEN), .DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst(rst), .line_start(line_start), .video(video), .tick(tick),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pos(wr_pos), .fill(fill), .ovf(ovf)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic we_b;
    assign we_b = wr_en & (wr_bank == bank_e'(b));
    lpc_bank #(.DEPTH(DEPTH), .POS_W(POS_W)) u_bank (
      .clk(clk), .we(we_b), .waddr(wr_idx), .wdata(wr_pos),
      .raddr(play_ptr[AW-1:0]), .rdata(bank_rd[b])
    );
  end

  // playback reads the bank not being written
  assign rd_pos = bank_rd[other_bank(wr_bank)];

  lpc_playback #(.LINE_LEN(LINE_LEN), .ACTIVE_LEN(ACTIVE_LEN), .DEPTH(DEPTH)) u_play (
    .clk(clk), .rst(rst), .line_start(line_start), .tick(tick), .fill_in(fill),
    .rd_pos(rd_pos), .play_ptr(play_ptr), .play_len(play_len), .dot(dot)
  );
endmodule

// File: rtl/lpc_line_codec_chk.sv
module lpc_line_codec_chk #(
  parameter int LINE_LEN   = 600,
  parameter int ACTIVE_LEN = 512,
  parameter int DEPTH      = 32,
  localparam int CW = $clog2(LINE_LEN),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          line_start,
  input logic          dot,
  input logic          ovf,
  input logic [CW-1:0] tick,
  input logic [NW-1:0] fill,
  input logic [NW-1:0] play_ptr,
  input logic [NW-1:0] play_len
);
  // R3
  dot_single_chk: assert property (@(posedge clk) disable iff (rst)
    dot |=> !dot);

  // R5
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dot |-> ($past(tick) < CW'(ACTIVE_LEN)));

  // R6
  fill_limit_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= NW'(DEPTH));

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !ovf);

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> ($past(fill) == NW'(DEPTH)));

  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    play_ptr <= play_len);
endmodule

bind lpc_line_codec lpc_line_codec_chk #(
  .LINE_LEN(LINE_LEN), .ACTIVE_LEN(ACTIVE_LEN), .DEPTH(DEPTH)
) i_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .dot(dot), .ovf(ovf),
  .tick(tick), .fill(fill), .play_ptr(play_ptr), .play_len(play_len)
);

// File: tb/test_lpc_line_codec.sv
`timescale 1ns/1ps
module test_lpc_line_codec;
  localparam int LINE_LEN   = 600;
  localparam int ACTIVE_LEN = 512;
  localparam int DEPTH      = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic video = 1'b0;
  logic dot, ovf;

  always #2 clk = ~clk;

  lpc_line_codec #(.LINE_LEN(LINE_LEN), .ACTIVE_LEN(ACTIVE_LEN), .DEPTH(DEPTH)) i_lpc_line_codec (
    .clk(clk), .rst(rst), .line_start(line_start), .video(video), .dot(dot), .ovf(ovf)
  );

  int total = 0;
  int bad = 0;
  int pat_s [64];
  int pat_w [64];
  int pat_n = 0;
  int prev_p [64];
  int prev_n = 0;
  logic last_ovf, early_ovf;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_pat();
    pat_n = 0;
  endtask

  task automatic add_pulse(input int s, input int w);
    pat_s[pat_n] = s;
    pat_w[pat_n] = w;
    pat_n++;
  endtask

  function automatic bit vid_at(input int c);
    for (int i = 0; i < pat_n; i++)
      if (c >= pat_s[i] && c < pat_s[i] + pat_w[i]) return 1'b1;
    return 1'b0;
  endfunction

  // one line: drive the current pattern, check playback of the previous line
  task automatic run_line(input int len, input string tag);
    int exp_p [64];
    int exp_n;
    int cap [64];
    int cap_n;
    int obs [640];
    int obs_n;
    int m;
    exp_n = 0;
    cap_n = 0;
    obs_n = 0;
    for (int i = 0; i < prev_n; i++)
      if (prev_p[i] + 2 < len) begin
        exp_p[exp_n] = prev_p[i];
        exp_n++;
      end
    for (int i = 0; i < pat_n; i++)
      if (pat_s[i] < ACTIVE_LEN && cap_n < DEPTH) begin
        cap[cap_n] = pat_s[i];
        cap_n++;
      end
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      if (j >= 2 && dot) begin
        obs[obs_n] = j - 2;
        obs_n++;
      end
      if (j == 1) early_ovf = ovf;
      if (j == len - 1) last_ovf = ovf;
      line_start = (j == 0);
      video = (j >= 1) && vid_at(j - 1);
    end
    check(obs_n == exp_n, tag, "dot count", obs_n, exp_n);
    m = (obs_n < exp_n) ? obs_n : exp_n;
    for (int i = 0; i < m; i++)
      check(obs[i] == exp_p[i], tag, "dot position", obs[i], exp_p[i]);
    for (int i = 0; i < cap_n; i++) prev_p[i] = cap[i];
    prev_n = cap_n;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(dot == 1'b0, "R1", "dot in reset", int'(dot), 0);
    check(ovf == 1'b0, "R1", "ovf in reset", int'(ovf), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(dot == 1'b0, "R1", "dot after reset", int'(dot), 0);
    clear_pat();
    add_pulse(0, 1); add_pulse(10, 1); add_pulse(57, 3); add_pulse(200, 1); add_pulse(511, 1);
    run_line(LINE_LEN, "R1");
  endtask

  task automatic t_playback();
    clear_pat();
    run_line(LINE_LEN, "R2");
    run_line(LINE_LEN, "R4");
    add_pulse(30, 1); add_pulse(32, 1); add_pulse(34, 1);
    run_line(LINE_LEN, "R4");
    clear_pat();
    run_line(LINE_LEN, "R3");
  endtask

  task automatic t_sync();
    clear_pat();
    add_pulse(100, 1); add_pulse(512, 1); add_pulse(530, 4); add_pulse(597, 1);
    run_line(LINE_LEN, "R5");
    clear_pat();
    run_line(LINE_LEN, "R5");
  endtask

  task automatic t_overflow();
    clear_pat();
    for (int i = 0; i < 32; i++) add_pulse(5 + 3 * i, 1);
    run_line(LINE_LEN, "R6");
    check(last_ovf == 1'b0, "R7", "ovf with exactly 32", int'(last_ovf), 0);
    clear_pat();
    for (int i = 0; i < 40; i++) add_pulse(7 + 4 * i, 1);
    run_line(LINE_LEN, "R6");
    check(last_ovf == 1'b1, "R7", "ovf with 40", int'(last_ovf), 1);
    clear_pat();
    run_line(LINE_LEN, "R6");
    check(early_ovf == 1'b0, "R7", "ovf after line start", int'(early_ovf), 0);
  endtask

  task automatic t_level();
    clear_pat();
    add_pulse(20, 100); add_pulse(300, 211);
    run_line(LINE_LEN, "R8");
    clear_pat();
    run_line(LINE_LEN, "R8");
  endtask

  task automatic t_short();
    clear_pat();
    add_pulse(100, 1); add_pulse(400, 1);
    run_line(LINE_LEN, "R9");
    clear_pat();
    add_pulse(50, 1);
    run_line(300, "R9");
    clear_pat();
    run_line(LINE_LEN, "R9");
  endtask

  initial begin
    int cycles;
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_playback();
    t_sync();
    t_overflow();
    t_level();
    t_short();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule